// File: doc/BRIEF.md
# Dual-Gain HDR Pixel Combiner

This block takes two readings of the same pixel and merges them into one high-dynamic-range word. The first reading is a high-gain sample with good low-light precision. The second is a low-gain sample that still has usable range after the high-gain sample saturates. Both readings arrive already corrected for offset and gain nonuniformity.

First, the low-gain sample is multiplied by a programmable factor so that it lines up with the high-gain response. Next, the high-gain sample is compared against two thresholds taken from a programmable saturation level:
- In the bright region the output is the scaled low-gain value.
- In the dark region the output is the high-gain value.
- In the band between the two thresholds the output blends linearly from the high-gain value to the scaled low-gain value.

Both the input and the output use a valid/ready handshake. A word moves when valid and ready are both high at a rising clock edge. The three-stage pipeline advances whenever the output register is empty or the consumer is ready. When it cannot advance, `in_ready` drops and the output word is held unchanged. The upstream source must hold its word and keep `in_valid` high until that word is accepted. The configuration inputs must stay constant while pixels are in flight.

Top module: `hdr_combine`

## Requirements
- R1: The scaled low-gain value is `(in_s2 * cfg_scale + 128) >> 8`, where `cfg_scale` is unsigned with 8 fractional bits. The 20-bit output holds the full-scale product without overflow.
- R2: If `in_s1 < (cfg_sat >> 1)` and R3 does not apply, the output equals `in_s1`.
- R3: If `in_s1 >= (cfg_sat >> 1) + (cfg_sat >> 2)`, the output equals the scaled low-gain value. This test is applied first, so it wins when the two thresholds are equal.
- R4: Otherwise the weight is `w = floor((in_s1 - t_lo) * 256 / (t_hi - t_lo))`, with `t_lo`/`t_hi` the two thresholds above. The output is `in_s1 + ((w * (s2s - in_s1) + 128) >>> 8)`, where the shift is arithmetic (floor).
- R5: With `out_ready` held high, a word accepted in cycle N appears with `out_valid` high in cycle N+3.
- R6: While `out_valid` is high and `out_ready` is low, `out_hdr` and `out_valid` stay unchanged and `in_ready` is low. Otherwise `in_ready` is high.
- R7: After reset, `out_valid` is low and `in_ready` is high.
- R8: Every output lies between `in_s1` and the scaled low-gain value of its pixel, inclusive.
- R9: Each accepted pixel yields exactly one output, in arrival order. Idle cycles on the input yield no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_scale | input | 16 | Low-gain scale factor, 8 fractional bits |
| cfg_sat | input | 12 | High-gain saturation level |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept an input pixel |
| in_s1 | input | 12 | Corrected high-gain sample |
| in_s2 | input | 12 | Corrected low-gain sample |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts output |
| out_hdr | output | 20 | Combined HDR value |

## Verification
The bench drives the high-gain sample onto each threshold and onto the values one step on either side of it. A design with an off-by-one comparison there would pick the wrong gain or blend one step too early. It also covers the degenerate saturation levels where both thresholds coincide, where a design that divides by the zero band width would return garbage. It uses the full-scale scale factor and sample, where an undersized product would wrap. Random stalls check that a held word does not change or get lost or duplicated, and negative blend differences check that rounding floors rather than truncates toward zero.

// File: rtl/hdr_pkg.sv
package hdr_pkg;
  localparam int WGT_BITS = 8;   // weight fraction bits (1.0 == 256)
  localparam int SCL_FRAC = 8;   // scale factor fraction bits

  typedef enum logic [1:0] {
    SEL_HG  = 2'd0,
    SEL_LG  = 2'd1,
    SEL_MIX = 2'd2
  } gain_sel_e;
endpackage

// File: rtl/hdr_scale_stage.sv
module hdr_scale_stage #(
  parameter int S1W = 12,
  parameter int S2W = 12,
  parameter int SCW = 16,
  parameter int OW  = S2W + SCW - hdr_pkg::SCL_FRAC
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  input  logic           v_i,
  input  logic [S1W-1:0] s1_i,
  input  logic [S2W-1:0] s2_i,
  input  logic [SCW-1:0] scale_i,
  input  logic [S1W-1:0] sat_i,
  output logic           v_o,
  output logic [S1W-1:0] s1_o,
  output logic [OW-1:0]  s2s_o,
  output logic [S1W-1:0] tlo_o,
  output logic [S1W-1:0] thi_o
);
  localparam int PW = S2W + SCW;
  localparam logic [PW-1:0] HALF = PW'(1) << (hdr_pkg::SCL_FRAC - 1);

  logic [PW-1:0]  prod;
  logic [PW-1:0]  rnd;
  logic [S1W-1:0] half_sat, qtr_sat;

  always_comb begin
    prod     = PW'(s2_i) * PW'(scale_i);
    rnd      = prod + HALF;
    half_sat = sat_i >> 1;
    qtr_sat  = sat_i >> 2;
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else if (adv) v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (adv && v_i) begin
      s1_o  <= s1_i;
      s2s_o <= OW'(rnd >> hdr_pkg::SCL_FRAC);
      tlo_o <= half_sat;
      thi_o <= half_sat + qtr_sat;
    end
  end

  // thresholds ordered: three-quarter point never below half point (R4)
  assert_thresh_order_R4: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (thi_o >= tlo_o));
endmodule

// File: rtl/hdr_region_stage.sv
module hdr_region_stage #(
  parameter int S1W = 12,
  parameter int OW  = 20
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          adv,
  input  logic                          v_i,
  input  logic [S1W-1:0]                s1_i,
  input  logic [OW-1:0]                 s2s_i,
  input  logic [S1W-1:0]                tlo_i,
  input  logic [S1W-1:0]                thi_i,
  output logic                          v_o,
  output logic [S1W-1:0]                s1_o,
  output logic [OW-1:0]                 s2s_o,
  output hdr_pkg::gain_sel_e            sel_o,
  output logic [hdr_pkg::WGT_BITS-1:0]  w_o
);
  import hdr_pkg::*;
  localparam int RW = S1W + 1;

  gain_sel_e          sel_c;
  logic [WGT_BITS-1:0] q_c;
  logic [S1W-1:0]     band, offs;
  logic [RW-1:0]      rem;

  // restoring division: q = floor(offs * 2^WGT_BITS / band), offs < band
  always_comb begin
    band = thi_i - tlo_i;
    offs = s1_i - tlo_i;
    rem  = RW'(offs);
    q_c  = '0;
    for (int i = WGT_BITS - 1; i >= 0; i--) begin
      rem = rem << 1;
      if (rem >= RW'(band)) begin
        rem    = rem - RW'(band);
        q_c[i] = 1'b1;
      end
    end
    if (s1_i >= thi_i)     sel_c = SEL_LG;
    else if (s1_i < tlo_i) sel_c = SEL_HG;
    else                   sel_c = SEL_MIX;
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else if (adv) v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (adv && v_i) begin
      s1_o  <= s1_i;
      s2s_o <= s2s_i;
      sel_o <= sel_c;
      w_o   <= (sel_c == SEL_MIX) ? q_c : '0;
    end
  end

  // a blend is only chosen inside the band, using the previous stage's thresholds (R4)
  assert_mix_band_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && v_i) |=> ((sel_o == SEL_MIX) ==
      (($past(s1_i) >= $past(tlo_i)) && ($past(s1_i) < $past(thi_i)))));
  // high-gain pass only below the half point (R2)
  assert_hg_region_R2: assert property (@(posedge clk) disable iff (rst)
    (adv && v_i && (s1_i < tlo_i)) |=> (sel_o == SEL_HG));
endmodule

// File: rtl/hdr_blend_stage.sv
module hdr_blend_stage #(
  parameter int S1W = 12,
  parameter int OW  = 20
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          adv,
  input  logic                          v_i,
  input  logic [S1W-1:0]                s1_i,
  input  logic [OW-1:0]                 s2s_i,
  input  hdr_pkg::gain_sel_e            sel_i,
  input  logic [hdr_pkg::WGT_BITS-1:0]  w_i,
  output logic                          v_o,
  output logic [OW-1:0]                 d_o
);
  import hdr_pkg::*;
  localparam int DW = OW + 1;
  localparam int MW = DW + WGT_BITS + 1;

  logic signed [DW-1:0] diff;
  logic signed [MW-1:0] prod, rnd, step;
  logic [OW-1:0]        s1x, mix;

  always_comb begin
    s1x  = OW'(s1_i);
    diff = $signed({1'b0, s2s_i}) - $signed({1'b0, s1x});
    prod = MW'(diff) * $signed({{(MW-WGT_BITS){1'b0}}, w_i});
    rnd  = prod + MW'(1 << (WGT_BITS - 1));
    step = rnd >>> WGT_BITS;
    mix  = s1x + OW'(step);
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else if (adv) v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (adv && v_i) begin
      case (sel_i)
        SEL_LG:  d_o <= s2s_i;
        SEL_HG:  d_o <= s1x;
        default: d_o <= mix;
      endcase
    end
  end

  // result bounded by its two sources (R8)
  assert_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    (adv && v_i) |=> ((d_o >= (($past(s2s_i) < OW'($past(s1_i))) ? $past(s2s_i) : OW'($past(s1_i)))) &&
                      (d_o <= (($past(s2s_i) > OW'($past(s1_i))) ? $past(s2s_i) : OW'($past(s1_i))))));
  // bright pixels pass the scaled low-gain value (R3)
  assert_lg_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && v_i && (sel_i == SEL_LG)) |=> (d_o == $past(s2s_i)));
  // bubbles create no output (R9)
  assert_bubble_R9: assert property (@(posedge clk) disable iff (rst)
    (adv && !v_i) |=> !v_o);
endmodule

// File: rtl/hdr_combine.sv
module hdr_combine #(
  parameter int S1W = 12,
  parameter int S2W = 12,
  parameter int SCW = 16,
  parameter int OW  = S2W + SCW - hdr_pkg::SCL_FRAC
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [SCW-1:0] cfg_scale,
  input  logic [S1W-1:0] cfg_sat,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [S1W-1:0] in_s1,
  input  logic [S2W-1:0] in_s2,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [OW-1:0]  out_hdr
);
  import hdr_pkg::*;

  logic                adv;
  logic                v1, v2;
  logic [S1W-1:0]      s1_a, s1_b, tlo_a, thi_a;
  logic [OW-1:0]       s2s_a, s2s_b;
  gain_sel_e           sel_b;
  logic [WGT_BITS-1:0] w_b;

  assign adv      = out_ready || !out_valid;
  assign in_ready = adv;

  hdr_scale_stage #(.S1W(S1W), .S2W(S2W), .SCW(SCW), .OW(OW)) u_scale (
    .clk, .rst, .adv, .v_i(in_valid), .s1_i(in_s1), .s2_i(in_s2),
    .scale_i(cfg_scale), .sat_i(cfg_sat), .v_o(v1), .s1_o(s1_a),
    .s2s_o(s2s_a), .tlo_o(tlo_a), .thi_o(thi_a));

  hdr_region_stage #(.S1W(S1W), .OW(OW)) u_region (
    .clk, .rst, .adv, .v_i(v1), .s1_i(s1_a), .s2s_i(s2s_a),
    .tlo_i(tlo_a), .thi_i(thi_a), .v_o(v2), .s1_o(s1_b),
    .s2s_o(s2s_b), .sel_o(sel_b), .w_o(w_b));

  hdr_blend_stage #(.S1W(S1W), .OW(OW)) u_blend (
    .clk, .rst, .adv, .v_i(v2), .s1_i(s1_b), .s2s_i(s2s_b),
    .sel_i(sel_b), .w_i(w_b), .v_o(out_valid), .d_o(out_hdr));

  // stalled output word holds (R6)
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hdr)));
  // no acceptance while the output is blocked (R6)
  assert_block_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/hdr_combine_tb.sv
module hdr_combine_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cfg_scale;
  logic [11:0] cfg_sat;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [11:0] in_s1, in_s2;
  logic [19:0] out_hdr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int stall_pct = 0;
  longint exp_q[$];
  string  tag_q[$];

  always #5 clk = ~clk;

  hdr_combine u_dut (
    .clk, .rst, .cfg_scale, .cfg_sat, .in_valid, .in_ready, .in_s1, .in_s2,
    .out_valid, .out_ready, .out_hdr);

  function automatic longint scaled(longint s2, longint sc);
    return (s2 * sc + 128) >> 8;  // R1
  endfunction

  function automatic longint model(longint s1, longint s2, longint sc, longint sat,
                                   output string tag);
    longint s2s, tlo, thi, w, p;
    s2s = scaled(s2, sc);
    tlo = sat >> 1;
    thi = tlo + (sat >> 2);
    if (s1 >= thi) begin tag = "R3"; return s2s; end
    if (s1 < tlo)  begin tag = "R2"; return s1; end
    tag = "R4";
    w = ((s1 - tlo) * 256) / (thi - tlo);
    p = w * (s2s - s1);
    return s1 + ((p + 128) >>> 8);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, then observe the handshakes of the next edge
  task automatic step(bit iv, logic [11:0] a, logic [11:0] b, output bit acc);
    string t;
    longint e;
    @(negedge clk);
    in_valid  = iv;
    in_s1     = a;
    in_s2     = b;
    out_ready = ($urandom_range(99) >= stall_pct);
    #1;
    check(in_ready == (out_ready || !out_valid), "R6", in_ready, out_ready || !out_valid);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(0, "R9", out_hdr, -1);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_hdr == e, t, out_hdr, e);
      end
    end
    acc = iv && in_ready;
    if (acc) begin
      e = model(a, b, cfg_scale, cfg_sat, t);
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
  endtask

  task automatic send(logic [11:0] a, logic [11:0] b);
    bit acc;
    do step(1'b1, a, b, acc); while (!acc);
  endtask

  task automatic drain();
    bit acc;
    int n = 0;
    while ((exp_q.size() != 0 || out_valid) && n < 1000) begin
      step(1'b0, '0, '0, acc);
      n++;
    end
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);
  endtask

  initial begin
    bit acc;
    logic [19:0] held;
    int lat;
    void'($urandom(32'h1234_5678));
    rst = 1'b1; in_valid = 0; in_s1 = 0; in_s2 = 0; out_ready = 1;
    cfg_scale = 16'd256; cfg_sat = 12'd2000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R7", out_valid, 0);
    check(in_ready, "R7", in_ready, 1);

    // R2/R3/R4 directed threshold edges: tlo=1000, thi=1500
    cfg_scale = 16'd1024;
    send(12'd999, 12'd300);   // R2 just below half point
    send(12'd1000, 12'd300);  // R4 w=0
    send(12'd1001, 12'd200);  // R4 negative diff, floor rounding
    send(12'd1499, 12'd700);  // R4 top of band
    send(12'd1500, 12'd100);  // R3 at three-quarter point
    send(12'd1250, 12'd10);   // R4 midpoint, negative diff
    drain();

    // R3 degenerate thresholds
    cfg_sat = 12'd0;
    send(12'd0, 12'd77);
    drain();
    cfg_sat = 12'd3;          // tlo=thi=1
    send(12'd0, 12'd50);
    send(12'd1, 12'd50);
    drain();

    // R1 full-scale product
    cfg_sat = 12'd0; cfg_scale = 16'hFFFF;
    send(12'hFFF, 12'hFFF);
    send(12'd0, 12'd1);       // rounding of a tiny product
    drain();

    // R5 latency with ready held high
    stall_pct = 0;
    cfg_scale = 16'd256; cfg_sat = 12'd4000;
    step(1'b1, 12'd10, 12'd20, acc);
    lat = 0;
    do begin
      step(1'b0, '0, '0, acc);
      lat++;
    end while (!out_valid && lat < 10);
    check(lat == 3, "R5", lat, 3);
    drain();

    // R6 hold under back-pressure
    stall_pct = 100;
    step(1'b1, 12'd3000, 12'd900, acc);
    repeat (4) step(1'b0, '0, '0, acc);
    held = out_hdr;
    check(out_valid, "R6", out_valid, 1);
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 12'd5, 12'd5, acc);
      check(!acc, "R6", acc, 0);
      check(out_valid && out_hdr == held, "R6", out_hdr, held);
    end
    stall_pct = 0;
    drain();

    // R8/R9 random traffic with bubbles and stalls, near-threshold bias
    for (int c = 0; c < 6; c++) begin
      cfg_sat   = 12'($urandom_range(4095));
      cfg_scale = 16'($urandom_range(65535));
      stall_pct = (c % 3) * 30;
      for (int k = 0; k < 250; k++) begin
        logic [11:0] a;
        if ($urandom_range(3) == 0) a = 12'($urandom_range(4095));
        else a = 12'(((cfg_sat >> 1) + $urandom_range(32'(cfg_sat >> 2) + 2)) - 1);
        if ($urandom_range(4) == 0) step(1'b0, '0, '0, acc);
        else send(a, 12'($urandom_range(4095)));
      end
      drain();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule